// File: doc/BRIEF.md
# Pointer Register Address Generator

This unit turns one of three 16-bit pointers into a data-memory address, a program-memory byte address or a jump target. The pointers are called X, Y and Z. Each pointer is two 8-bit registers held in the register file, with the low byte in the lower-numbered register. The register file presents the three pointers to the unit, and the unit never stores them. An access is requested with an operation code, an addressing mode, a pointer select, a 6-bit unsigned offset, a 16-bit constant and a destination register index. The unit takes the request on a clock edge when `ready` is high. Its results appear in registers during the cycle after that edge.

There are five addressing modes: plain, post-increment, pre-decrement, offset and constant. Only post-increment and pre-decrement change the pointer. In those two modes the unit gives the register file a one-cycle write-back of the new pointer value. The register file writes it before the next access can be accepted, so the following access sees the updated pointer. Each kind of operation occupies the unit for a fixed number of cycles, and `done` marks the last of those cycles.

Top module: `ptr_agu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the outputs are as follows: `ready` is 1; `done`, `mem_en`, `mem_we`, `prog_en`, `pc_load`, `pc_push` and `wb_en` are 0; `mem_addr`, `prog_addr`, `pc_target`, `wb_val`, `wb_sel` and `rd_sel` are 0.
- R2: Pointer select codes are 0 for X, 1 for Y, and 2 or 3 for Z. Mode code 0 (plain) with a load (op 0) or a store (op 1) puts the selected pointer on `mem_addr` and raises no write-back.
- R3: Mode code 1 (post-increment) puts the current pointer on `mem_addr`. It also pulses `wb_en` with `wb_val` equal to the pointer plus one, wrapping from 16'hFFFF to 16'h0000, and `wb_sel` equal to the pointer's index (0, 1 or 2).
- R4: Mode code 2 (pre-decrement) uses the pointer minus one, wrapping from 16'h0000 to 16'hFFFF. That value appears on both `mem_addr` and `wb_val`, and `wb_en` pulses.
- R5: Mode code 3 (offset) puts Y or Z plus the zero-extended 6-bit `disp` (0 to 63) on `mem_addr`, modulo 2^16, and raises no write-back. With X selected, the offset is ignored and the address is X.
- R6: Mode code 4 (constant) puts `kaddr` on `mem_addr` whatever the pointers hold, and raises no write-back.
- R7: Results of an accepted request appear in the cycle after the accepting edge. A load or a store occupies 2 cycles: `done` is high and `ready` returns in the second cycle, so requests can be accepted on every other edge.
- R8: Op 2 (program-memory read) pulses `prog_en` with `prog_addr` equal to Z and occupies 3 cycles. The mode is ignored for this op, and it raises no write-back. `rd_sel` is `dst`, or 0 when `dst_none` is high.
- R9: Op 3 (jump) and op 4 (call) pulse `pc_load` with `pc_target` equal to Z. Only a call also pulses `pc_push`. A jump occupies 2 cycles and a call occupies 3.
- R10: `mem_we` pulses together with `mem_en` for a store and stays 0 for a load. A load sets `rd_sel` to `dst`.
- R11: A request made while `ready` is low is dropped, and so is one that carries op code 5, 6 or 7. Neither raises any strobe or changes `ready`. Mode codes 5 to 7 behave as plain.
- R12: After a post-increment or pre-decrement, the next access through the same pointer uses the written-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid |
| op | input | 3 | 0 load, 1 store, 2 program read, 3 jump, 4 call |
| amode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 offset, 4 constant |
| psel | input | 2 | Pointer select: 0 X, 1 Y, 2/3 Z |
| disp | input | 6 | Unsigned offset |
| kaddr | input | 16 | Constant address |
| dst | input | 5 | Destination register index |
| dst_none | input | 1 | Program read without a destination (writes register 0) |
| x_ptr | input | 16 | Pointer X from the register file |
| y_ptr | input | 16 | Pointer Y from the register file |
| z_ptr | input | 16 | Pointer Z from the register file |
| ready | output | 1 | A request is accepted on this edge |
| done | output | 1 | Last cycle of the current operation |
| mem_en | output | 1 | Data memory access strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Effective data address |
| prog_en | output | 1 | Program memory read strobe |
| prog_addr | output | 16 | Program memory byte address |
| pc_load | output | 1 | Program counter load strobe |
| pc_push | output | 1 | Return address push strobe (call) |
| pc_target | output | 16 | New program counter value |
| rd_sel | output | 5 | Register receiving loaded data |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer index for write-back |
| wb_val | output | 16 | Updated pointer value |

## Verification
The bench goes after the wrap points: a post-increment from 16'hFFFF, a pre-decrement from 16'h0000, and an offset of 63 that carries out of the low byte. A design that swapped the ordering of increment and decrement, or truncated the carry, would put the wrong address on `mem_addr` in those cases. It also sends offset mode with X selected, which a careless adder would offset anyway. It sends requests while the unit is busy and sends reserved op codes; a design that lacked the guards on these would fire stray strobes or lose its cycle count. Chains of post-increment accesses check that a write-back is in place before the next access. A behavioural model compares every output on every clock over a long random run.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_LD   = 3'd0,
    OP_ST   = 3'd1,
    OP_LPM  = 3'd2,
    OP_JMP  = 3'd3,
    OP_CALL = 3'd4
  } agu_op_e;

  typedef enum logic [2:0] {
    AM_PLAIN  = 3'd0,
    AM_POST   = 3'd1,
    AM_PRE    = 3'd2,
    AM_DISP   = 3'd3,
    AM_DIRECT = 3'd4
  } agu_mode_e;

  localparam logic [1:0] PTR_X = 2'd0;
  localparam logic [1:0] PTR_Y = 2'd1;
  localparam logic [1:0] PTR_Z = 2'd2;

  localparam int LEN_W      = 2;
  localparam int CYC_DATA   = 2;
  localparam int CYC_PROG   = 3;
  localparam int CYC_JUMP   = 2;
  localparam int CYC_CALL   = 3;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic [LEN_W-1:0] op_cycles(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      OP_LPM:  n = LEN_W'(CYC_PROG);
      OP_JMP:  n = LEN_W'(CYC_JUMP);
      OP_CALL: n = LEN_W'(CYC_CALL);
      default: n = LEN_W'(CYC_DATA);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
  parameter int AW      = 16,
  parameter int NUM_PTR = 3
) (
  input  logic [AW-1:0] x_ptr,
  input  logic [AW-1:0] y_ptr,
  input  logic [AW-1:0] z_ptr,
  input  logic [1:0]    psel,
  output logic [AW-1:0] ptr,
  output logic [1:0]    ptr_id
);
  localparam int LAST = NUM_PTR - 1;

  logic [AW-1:0] bank [NUM_PTR];

  assign bank[0] = x_ptr;
  assign bank[1] = y_ptr;
  assign bank[2] = z_ptr;

  // any code at or above the last pointer folds onto it
  assign ptr_id = (int'(psel) >= LAST) ? 2'(LAST) : psel;

  always_comb begin
    ptr = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (ptr_id == 2'(i)) ptr = bank[i];
    end
  end
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    ptr_id,
  input  logic [2:0]    amode,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] kaddr,
  output logic [AW-1:0] ea,
  output logic          wb_need,
  output logic [AW-1:0] wb_val
);
  localparam int PAD = AW - DW;

  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_off;
  logic          off_ok;

  assign ptr_inc = ptr + AW'(1);
  assign ptr_dec = ptr - AW'(1);
  assign ptr_off = ptr + {{PAD{1'b0}}, disp};
  assign off_ok  = (ptr_id != PTR_X);

  always_comb begin
    ea      = ptr;
    wb_need = 1'b0;
    wb_val  = ptr;
    case (amode)
      AM_POST: begin
        wb_need = 1'b1;
        wb_val  = ptr_inc;
      end
      AM_PRE: begin
        ea      = ptr_dec;
        wb_need = 1'b1;
        wb_val  = ptr_dec;
      end
      AM_DISP:   ea = off_ok ? ptr_off : ptr;
      AM_DIRECT: ea = kaddr;
      default:   ea = ptr;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  output logic             ready,
  output logic             done
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;

  assign done  = (cnt != '0) && (cnt == len_q);
  assign ready = (cnt == '0) || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      len_q <= '0;
    end else if (start) begin
      cnt   <= LEN_W'(1);
      len_q <= start_len;
    end else if (cnt != '0) begin
      cnt <= done ? '0 : cnt + LEN_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= len_q); // R7
  AST_START_STEP: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == LEN_W'(1))); // R7
  AST_START_READY: assert property (@(posedge clk) disable iff (rst)
    start |-> ready); // R11
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 6,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic [2:0]     op,
  input  logic [2:0]     amode,
  input  logic [1:0]     psel,
  input  logic [DW-1:0]  disp,
  input  logic [AW-1:0]  kaddr,
  input  logic [RIW-1:0] dst,
  input  logic           dst_none,
  input  logic [AW-1:0]  x_ptr,
  input  logic [AW-1:0]  y_ptr,
  input  logic [AW-1:0]  z_ptr,
  output logic           ready,
  output logic           done,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic           prog_en,
  output logic [AW-1:0]  prog_addr,
  output logic           pc_load,
  output logic           pc_push,
  output logic [AW-1:0]  pc_target,
  output logic [RIW-1:0] rd_sel,
  output logic           wb_en,
  output logic [1:0]     wb_sel,
  output logic [AW-1:0]  wb_val
);
  logic [AW-1:0] sel_ptr;
  logic [1:0]    sel_id;
  logic [AW-1:0] ea;
  logic          wb_need;
  logic [AW-1:0] nxt_ptr;
  logic          accept;
  logic          is_data;

  agu_ptr_mux #(.AW(AW), .NUM_PTR(3)) u_mux (
    .x_ptr (x_ptr),
    .y_ptr (y_ptr),
    .z_ptr (z_ptr),
    .psel  (psel),
    .ptr   (sel_ptr),
    .ptr_id(sel_id)
  );

  agu_ea_calc #(.AW(AW), .DW(DW)) u_ea (
    .ptr    (sel_ptr),
    .ptr_id (sel_id),
    .amode  (amode),
    .disp   (disp),
    .kaddr  (kaddr),
    .ea     (ea),
    .wb_need(wb_need),
    .wb_val (nxt_ptr)
  );

  assign accept  = req && ready && op_known(op);
  assign is_data = (op == OP_LD) || (op == OP_ST);

  agu_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .start_len(op_cycles(op)),
    .ready    (ready),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      prog_en   <= 1'b0;
      prog_addr <= '0;
      pc_load   <= 1'b0;
      pc_push   <= 1'b0;
      pc_target <= '0;
      rd_sel    <= '0;
      wb_en     <= 1'b0;
      wb_sel    <= '0;
      wb_val    <= '0;
    end else begin
      mem_en  <= 1'b0;
      mem_we  <= 1'b0;
      prog_en <= 1'b0;
      pc_load <= 1'b0;
      pc_push <= 1'b0;
      wb_en   <= 1'b0;
      if (accept) begin
        rd_sel <= '0;
        if (is_data) begin
          mem_en   <= 1'b1;
          mem_we   <= (op == OP_ST);
          mem_addr <= ea;
          wb_en    <= wb_need;
          if (op == OP_LD) rd_sel <= dst;
          if (wb_need) begin
            wb_sel <= sel_id;
            wb_val <= nxt_ptr;
          end
        end else if (op == OP_LPM) begin
          prog_en   <= 1'b1;
          prog_addr <= z_ptr;
          rd_sel    <= dst_none ? '0 : dst;
        end else begin
          pc_load   <= 1'b1;
          pc_push   <= (op == OP_CALL);
          pc_target <= z_ptr;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_en, prog_en, pc_load})); // R7
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en); // R7
  AST_WB_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> mem_en); // R3
  AST_WB_STEP: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ((wb_val == mem_addr + AW'(1)) || (wb_val == mem_addr))); // R4
  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en); // R10
  AST_PUSH_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
    pc_push |-> pc_load); // R9
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (mem_en || prog_en || pc_load) |-> !done); // R8
endmodule

// File: tb/ptr_agu_test.sv
`timescale 1ns/1ps
module ptr_agu_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [2:0] op = '0, amode = '0;
  logic [1:0] psel = '0;
  logic [5:0] disp = '0;
  logic [15:0] kaddr = '0;
  logic [4:0] dst = '0;
  logic dst_none = 1'b0;
  logic [15:0] xr = '0, yr = '0, zr = '0;

  logic ready, done, mem_en, mem_we, prog_en, pc_load, pc_push, wb_en;
  logic [15:0] mem_addr, prog_addr, pc_target, wb_val;
  logic [4:0] rd_sel;
  logic [1:0] wb_sel;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ptr_agu uut (
    .clk(clk), .rst(rst), .req(req), .op(op), .amode(amode), .psel(psel),
    .disp(disp), .kaddr(kaddr), .dst(dst), .dst_none(dst_none),
    .x_ptr(xr), .y_ptr(yr), .z_ptr(zr),
    .ready(ready), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .prog_en(prog_en), .prog_addr(prog_addr),
    .pc_load(pc_load), .pc_push(pc_push), .pc_target(pc_target),
    .rd_sel(rd_sel), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );

  // behavioural reference state
  int m_cnt = 0, m_len = 0;
  int m_mem_en = 0, m_mem_we = 0, m_prog_en = 0, m_pc_load = 0, m_pc_push = 0, m_wb_en = 0;
  int m_mem_addr = 0, m_prog_addr = 0, m_pc_target = 0, m_rd = 0, m_wb_sel = 0, m_wb_val = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ptr_of(input int s);
    if (s == 0) return int'(xr);
    if (s == 1) return int'(yr);
    return int'(zr);
  endfunction

  task automatic model_step();
    int p, id, len;
    bit rdy, acc;
    rdy = (m_cnt == 0) || (m_cnt == m_len);
    m_mem_en = 0; m_mem_we = 0; m_prog_en = 0; m_pc_load = 0; m_pc_push = 0; m_wb_en = 0;
    if (rst) begin
      m_cnt = 0; m_len = 0; m_mem_addr = 0; m_prog_addr = 0; m_pc_target = 0;
      m_rd = 0; m_wb_sel = 0; m_wb_val = 0;
      return;
    end
    acc = req && rdy && (op <= 3'd4);
    if (acc) begin
      if (op == 3'd2 || op == 3'd4) len = 3; else len = 2;
      m_cnt = 1; m_len = len;
    end else if (m_cnt != 0) begin
      m_cnt = (m_cnt == m_len) ? 0 : m_cnt + 1;
    end
    if (!acc) return;
    m_rd = 0;
    id = (psel >= 2) ? 2 : int'(psel);
    p  = ptr_of(id);
    if (op <= 3'd1) begin
      m_mem_en = 1;
      m_mem_we = (op == 3'd1);
      if (op == 3'd0) m_rd = int'(dst);
      case (amode)
        3'd1: begin m_mem_addr = p; m_wb_en = 1; m_wb_val = (p + 1) & 16'hFFFF; end
        3'd2: begin m_mem_addr = (p + 16'hFFFF) & 16'hFFFF; m_wb_en = 1; m_wb_val = m_mem_addr; end
        3'd3: m_mem_addr = (id == 0) ? p : ((p + int'(disp)) & 16'hFFFF);
        3'd4: m_mem_addr = int'(kaddr);
        default: m_mem_addr = p;
      endcase
      if (m_wb_en != 0) m_wb_sel = id;
    end else if (op == 3'd2) begin
      m_prog_en = 1; m_prog_addr = int'(zr);
      m_rd = dst_none ? 0 : int'(dst);
    end else begin
      m_pc_load = 1; m_pc_push = (op == 3'd4); m_pc_target = int'(zr);
    end
  endtask

  task automatic compare();
    bit m_rdy, m_dn;
    m_dn  = (m_cnt != 0) && (m_cnt == m_len);
    m_rdy = (m_cnt == 0) || m_dn;
    chk("R7 ready", int'(ready), int'(m_rdy));
    chk("R7 done", int'(done), int'(m_dn));
    chk("R2 mem_en", int'(mem_en), m_mem_en);
    chk("R10 mem_we", int'(mem_we), m_mem_we);
    chk("R2 mem_addr", int'(mem_addr), m_mem_addr);
    chk("R8 prog_en", int'(prog_en), m_prog_en);
    chk("R8 prog_addr", int'(prog_addr), m_prog_addr);
    chk("R9 pc_load", int'(pc_load), m_pc_load);
    chk("R9 pc_push", int'(pc_push), m_pc_push);
    chk("R9 pc_target", int'(pc_target), m_pc_target);
    chk("R10 rd_sel", int'(rd_sel), m_rd);
    chk("R3 wb_en", int'(wb_en), m_wb_en);
    chk("R3 wb_sel", int'(wb_sel), m_wb_sel);
    chk("R3 wb_val", int'(wb_val), m_wb_val);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    compare();
    if (wb_en) begin
      if (wb_sel == 2'd0) xr = wb_val;
      else if (wb_sel == 2'd1) yr = wb_val;
      else zr = wb_val;
    end
  endtask

  task automatic issue(input int o, input int am, input int ps, input int d,
                       input int k, input int ds, input bit dn);
    while (!ready) tick();
    req = 1'b1; op = 3'(o); amode = 3'(am); psel = 2'(ps);
    disp = 6'(d); kaddr = 16'(k); dst = 5'(ds); dst_none = dn;
    tick();
    req = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 ready", int'(ready), 1);
    chk("R1 strobes", int'({done, mem_en, mem_we, prog_en, pc_load, pc_push, wb_en}), 0);
    chk("R1 addresses", int'(mem_addr | prog_addr | pc_target | wb_val), 0);
    chk("R1 sel", int'({rd_sel, wb_sel}), 0);

    xr = 16'h1000; yr = 16'h20F0; zr = 16'hFFFF;
    issue(0, 0, 0, 0, 0, 5, 0);
    chk("R2 plain X", int'(mem_addr), 16'h1000);
    chk("R10 load dst", int'(rd_sel), 5);
    chk("R2 no wb", int'(wb_en), 0);
    tick();
    chk("R7 done on 2nd cycle", int'(done & ready), 1);

    issue(1, 1, 2, 0, 0, 0, 0);
    chk("R3 post addr", int'(mem_addr), 16'hFFFF);
    chk("R3 post wrap", int'(wb_val), 16'h0000);
    chk("R3 wb_sel Z", int'(wb_sel), 2);
    chk("R10 store we", int'(mem_we), 1);

    issue(0, 2, 3, 0, 0, 1, 0);
    chk("R4 pre wrap, R12 sees write-back", int'(mem_addr), 16'hFFFF);
    chk("R4 pre wb", int'(wb_val), 16'hFFFF);

    issue(0, 3, 1, 63, 0, 2, 0);
    chk("R5 disp Y 63", int'(mem_addr), 16'h212F);
    chk("R5 no wb", int'(wb_en), 0);
    issue(0, 3, 0, 10, 0, 2, 0);
    chk("R5 disp ignored on X", int'(mem_addr), 16'h1000);

    issue(1, 4, 0, 0, 16'hBEEF, 0, 0);
    chk("R6 direct", int'(mem_addr), 16'hBEEF);
    chk("R6 no wb", int'(wb_en), 0);

    zr = 16'h0ABC;
    issue(2, 1, 0, 0, 0, 9, 1);
    chk("R8 prog addr Z", int'(prog_addr), 16'h0ABC);
    chk("R8 no dst -> r0", int'(rd_sel), 0);
    chk("R8 mode ignored", int'(wb_en), 0);
    tick();
    chk("R8 not done yet", int'(done), 0);
    tick();
    chk("R8 done on 3rd cycle", int'(done), 1);
    issue(2, 0, 0, 0, 0, 9, 0);
    chk("R8 dst", int'(rd_sel), 9);

    issue(3, 0, 0, 0, 0, 0, 0);
    chk("R9 jump target", int'(pc_target), 16'h0ABC);
    chk("R9 jump no push", int'(pc_push), 0);
    tick();
    chk("R9 jump 2 cycles", int'(done), 1);
    issue(4, 0, 0, 0, 0, 0, 0);
    chk("R9 call push", int'({pc_load, pc_push}), 3);

    // R11 busy request dropped
    issue(0, 0, 1, 0, 0, 3, 0);
    req = 1'b1; op = 3'd1; tick(); req = 1'b0;
    chk("R11 busy drop", int'(mem_en), 0);
    while (!ready) tick();
    req = 1'b1; op = 3'd6; tick(); req = 1'b0;
    chk("R11 reserved op", int'({mem_en, prog_en, pc_load}), 0);
    chk("R11 ready kept", int'(ready), 1);
    issue(0, 7, 1, 5, 0, 3, 0);
    chk("R11 reserved mode plain", int'(mem_addr), 16'h20F0);

    // R12 chain of post-increments on X
    xr = 16'h00FE;
    for (int i = 0; i < 3; i++) begin
      issue(0, 1, 0, 0, 0, 4, 0);
      chk("R12 chain", int'(mem_addr), 16'h00FE + i);
    end

    for (int i = 0; i < 3000; i++) begin
      req = ($urandom_range(0, 3) != 0);
      op = 3'($urandom_range(0, 7)); amode = 3'($urandom_range(0, 7));
      psel = 2'($urandom); disp = 6'($urandom); kaddr = 16'($urandom);
      dst = 5'($urandom); dst_none = 1'($urandom);
      if ($urandom_range(0, 15) == 0) yr = 16'($urandom_range(16'hFFC0, 16'hFFFF));
      tick();
    end
    req = 1'b0;
    tick(); tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule